// File: doc/BRIEF.md
# Sideband AUX Request Framer and Packer

The block turns a host command (a 4-bit request code, a 20-bit target address, a payload length and up to 16 payload bytes) into the byte image of a sideband AUX request. It stores that image as five 32-bit words, most significant byte first, for a transmit engine to fetch by word index. Together with the image it reports the number of bytes to send and the reply length the engine should expect. It also raises a flag when the request is a native write to the protected key address, so that the engine can insert the hidden key bytes after the header.

On the return path the engine writes up to five received words by index and then signals completion with the received byte count. The block then decodes the reply. It gives the reply code, a byte count and an error flag, and it serves the received payload one byte at a time through an index port. Payload bytes beyond the length the caller asked for are never served.

The host loads payload bytes into a 16-entry buffer before it issues the command. The command port is always ready. Each command replaces the previous frame.

Top module: `aux_req_framer`

## Requirements
- R1: In an accepted frame, byte 0 carries the request code in bits 7:4 and address bits 19:16 in bits 3:0. Byte 1 carries address bits 15:8 and byte 2 carries address bits 7:0.
- R2: With a non-zero length, byte 3 holds the length minus one. Byte k of the image sits in word k/4 at bits (31-8*(k%4)) down to (24-8*(k%4)). Every byte at or beyond the transmit length reads as zero.
- R3: A zero-length request gives a transmit length of 3. Byte 3 and every later byte read as zero.
- R4: Request codes 0x0, 0x2 and 0x8 are write types. They give a transmit length of 4 plus the length (3 when the length is zero) and an expected reply length of 2. Payload buffer entry i appears as byte 4+i.
- R5: A write longer than 16 bytes, or a read longer than 19 bytes, is rejected with error code 2. The transmit length and expected length are then 0 and every word reads zero.
- R6: Request codes 0x1 and 0x9 are read types. They give a transmit length of 4 (3 at zero length) and an expected reply length of the length plus one.
- R7: Any other request code is rejected with error code 1. The transmit length and expected length are 0 and every word reads zero.
- R8: Bit 2 of the request code does not affect classification: 0x4, 0x6, 0xC, 0x5 and 0xD behave like the same codes with that bit clear. The full code is still placed in byte 0.
- R9: The key flag is 1 only for an accepted, error-free request whose code with bit 2 cleared is 0x8 and whose address equals KEY_ADDR (default 0x68007).
- R10: The reply code is bits 31:28 of received word 0. For a read, the count is the smaller of the received length and the expected length, minus one. Payload byte j (j < count) is received byte j+1, and every index at or beyond the count reads zero.
- R11: For a write, when at least two bytes are received, the count is received byte 1 clamped to the requested length. Otherwise the count is the requested length.
- R12: A received length of 0 or above 20, or a reply to a rejected frame, sets the response error flag and a count of 0.
- R13: The command port is always ready. The frame outputs pulse valid one cycle after a command is accepted, and the response pulses valid one cycle after the receive-done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pl_we | input | 1 | Payload buffer write strobe |
| pl_idx | input | 4 | Payload buffer entry index |
| pl_byte | input | 8 | Payload byte to store |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_req | input | 4 | Request code |
| cmd_addr | input | 20 | Target address |
| cmd_len | input | 5 | Payload length in bytes |
| frm_valid | output | 1 | One-cycle pulse: new frame ready |
| frm_err | output | 2 | 0 ok, 1 invalid code, 2 too long |
| frm_tx_len | output | 5 | Bytes to transmit |
| frm_rx_expect | output | 5 | Reply bytes expected |
| frm_key | output | 1 | Engine must append key bytes |
| tx_widx | input | 3 | Transmit word index |
| tx_word | output | 32 | Transmit word at tx_widx |
| rx_we | input | 1 | Received word write strobe |
| rx_widx | input | 3 | Received word index |
| rx_wdata | input | 32 | Received word |
| rx_done | input | 1 | Reception finished strobe |
| rx_len | input | 5 | Number of bytes received |
| rsp_valid | output | 1 | One-cycle pulse: reply decoded |
| rsp_err | output | 1 | Reply length invalid |
| rsp_code | output | 4 | Reply code |
| rsp_count | output | 5 | Payload bytes read or bytes written |
| rd_idx | input | 5 | Reply payload byte index |
| rd_byte | output | 8 | Reply payload byte at rd_idx |

## Verification
A command presented before a rising edge shows its frame outputs right after that edge: frm_valid pulses for one cycle, and the lengths, error code and key flag hold until the next command. The response fields follow the receive-done strobe by the same single edge. tx_word and rd_byte follow their index inputs within the same cycle. The reference model keeps the inputs driven before each edge and compares both valid pulses against its own prediction 5 ns after every edge. The word and byte reads are sampled 1 ns after each index change, so no check looks at a value that is still settling.

// File: rtl/aux_req_framer.sv
module aux_req_framer #(
  parameter int          MAXB     = 20,
  parameter logic [19:0] KEY_ADDR = 20'h68007
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pl_we,
  input  logic [$clog2(MAXB-4)-1:0]     pl_idx,
  input  logic [7:0]                    pl_byte,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [3:0]                    cmd_req,
  input  logic [19:0]                   cmd_addr,
  input  logic [$clog2(MAXB+1)-1:0]     cmd_len,
  output logic                          frm_valid,
  output logic [1:0]                    frm_err,
  output logic [$clog2(MAXB+1)-1:0]     frm_tx_len,
  output logic [$clog2(MAXB+1)-1:0]     frm_rx_expect,
  output logic                          frm_key,
  input  logic [$clog2((MAXB+3)/4)-1:0] tx_widx,
  output logic [31:0]                   tx_word,
  input  logic                          rx_we,
  input  logic [$clog2((MAXB+3)/4)-1:0] rx_widx,
  input  logic [31:0]                   rx_wdata,
  input  logic                          rx_done,
  input  logic [$clog2(MAXB+1)-1:0]     rx_len,
  output logic                          rsp_valid,
  output logic                          rsp_err,
  output logic [3:0]                    rsp_code,
  output logic [$clog2(MAXB+1)-1:0]     rsp_count,
  input  logic [$clog2(MAXB+1)-1:0]     rd_idx,
  output logic [7:0]                    rd_byte
);
  localparam int PLB = MAXB - 4;
  localparam int NW  = (MAXB + 3) / 4;
  localparam int LW  = $clog2(MAXB + 1);
  localparam int IW  = $clog2(NW);
  localparam int PW  = $clog2(PLB);

  logic [7:0]  plbuf [PLB];
  logic [7:0]  txb   [MAXB];
  logic [7:0]  nb    [MAXB];
  logic [31:0] rxw   [NW];
  logic [3:0]  base;
  logic        is_wr, is_rd, too_big, rd_q, rx_bad;
  logic [1:0]  err_c;
  logic [LW-1:0] txl, rxe, len_q, eff, cnt;
  logic [7:0]  b1;

  assign cmd_ready = 1'b1;
  assign base    = cmd_req & 4'hB;
  assign is_wr   = (base == 4'h0) || (base == 4'h2) || (base == 4'h8);
  assign is_rd   = (base == 4'h1) || (base == 4'h9);
  assign too_big = is_wr ? (int'(cmd_len) > PLB) : (int'(cmd_len) > MAXB - 1);
  assign err_c   = !(is_wr || is_rd) ? 2'd1 : too_big ? 2'd2 : 2'd0;

  always_comb begin
    if (err_c != 2'd0)    txl = '0;
    else if (cmd_len == 0) txl = LW'(3);
    else if (is_wr)        txl = LW'(4) + cmd_len;
    else                   txl = LW'(4);
    if (err_c != 2'd0)     rxe = '0;
    else if (is_wr)        rxe = LW'(2);
    else                   rxe = cmd_len + LW'(1);
  end

  always_comb begin
    for (int i = 0; i < MAXB; i++) nb[i] = 8'h00;
    if (err_c == 2'd0) begin
      nb[0] = {cmd_req, cmd_addr[19:16]};
      nb[1] = cmd_addr[15:8];
      nb[2] = cmd_addr[7:0];
      if (cmd_len != 0) nb[3] = 8'(cmd_len) - 8'd1;
      for (int i = 4; i < MAXB; i++)
        if (is_wr && (i - 4) < int'(cmd_len)) nb[i] = plbuf[PW'(i - 4)];
    end
  end

  always_ff @(posedge clk)
    if (pl_we) plbuf[pl_idx] <= pl_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_valid <= 1'b0; frm_err <= '0; frm_tx_len <= '0; frm_rx_expect <= '0;
      frm_key <= 1'b0; rd_q <= 1'b0; len_q <= '0;
      for (int i = 0; i < MAXB; i++) txb[i] <= 8'h00;
    end else begin
      frm_valid <= cmd_valid && cmd_ready;
      if (cmd_valid && cmd_ready) begin
        frm_err       <= err_c;
        frm_tx_len    <= txl;
        frm_rx_expect <= rxe;
        frm_key       <= (err_c == 2'd0) && (base == 4'h8) && (cmd_addr == KEY_ADDR);
        rd_q          <= is_rd;
        len_q         <= cmd_len;
        for (int i = 0; i < MAXB; i++) txb[i] <= nb[i];
      end
    end
  end

  always_comb begin
    tx_word = '0;
    for (int k = 0; k < NW; k++)
      if (int'(tx_widx) == k)
        for (int j = 0; j < 4; j++)
          if (4 * k + j < MAXB) tx_word[31 - 8 * j -: 8] = txb[4 * k + j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NW; k++) rxw[k] <= '0;
    end else if (rx_we && int'(rx_widx) < NW) begin
      rxw[rx_widx] <= rx_wdata;
    end
  end

  function automatic logic [7:0] rxb(input int k);
    if (k >= 4 * NW) return 8'h00;
    return rxw[IW'(k / 4)][8 * (3 - k % 4) +: 8];
  endfunction

  assign rx_bad = (rx_len == 0) || (int'(rx_len) > MAXB) || (frm_rx_expect == 0);
  assign eff    = (rx_len < frm_rx_expect) ? rx_len : frm_rx_expect;
  assign b1     = rxb(1);

  always_comb begin
    if (rx_bad)       cnt = '0;
    else if (rd_q)    cnt = eff - LW'(1);
    else if (eff > 1) cnt = (b1 < 8'(len_q)) ? LW'(b1) : len_q;
    else              cnt = len_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_code <= '0; rsp_count <= '0;
    end else begin
      rsp_valid <= rx_done;
      if (rx_done) begin
        rsp_err   <= rx_bad;
        rsp_code  <= rxw[0][31:28];
        rsp_count <= cnt;
      end
    end
  end

  assign rd_byte = (rd_idx < rsp_count) ? rxb(int'(rd_idx) + 1) : 8'h00;

  p_frm_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> $past(cmd_valid));
  p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rx_done));
  p_nosend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_err != 2'd0) |-> (frm_tx_len == 0 && frm_rx_expect == 0));
  p_txcap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_err == 2'd0) |-> (int'(frm_tx_len) <= MAXB && frm_tx_len >= 3));
  p_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_key |-> (!rd_q && frm_err == 2'd0));
  p_rdcnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rd_q && !rsp_err && !frm_valid) |-> (rsp_count < frm_rx_expect));
  p_wrcnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rd_q && !rsp_err && !frm_valid) |-> (rsp_count <= len_q));
  p_bad_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_count == 0));
endmodule

// File: tb/tb_aux_req_framer.sv
module tb_aux_req_framer;
  localparam logic [19:0] KEY = 20'h68007;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pl_we = 0; logic [3:0] pl_idx = 0; logic [7:0] pl_byte = 0;
  logic cmd_valid = 0, cmd_ready; logic [3:0] cmd_req = 0;
  logic [19:0] cmd_addr = 0; logic [4:0] cmd_len = 0;
  logic frm_valid, frm_key; logic [1:0] frm_err;
  logic [4:0] frm_tx_len, frm_rx_expect;
  logic [2:0] tx_widx = 0; logic [31:0] tx_word;
  logic rx_we = 0; logic [2:0] rx_widx = 0; logic [31:0] rx_wdata = 0;
  logic rx_done = 0; logic [4:0] rx_len = 0;
  logic rsp_valid, rsp_err; logic [3:0] rsp_code; logic [4:0] rsp_count;
  logic [4:0] rd_idx = 0; logic [7:0] rd_byte;

  int checks = 0, fails = 0, cyc = 0;
  int pl[16]; int eb[20]; int rb[20];
  int e_err, e_txl, e_rxe, e_key, e_rd, e_len;

  aux_req_framer dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    bit c = cmd_valid; bit d = rx_done;
    @(posedge clk); #5;
    if (rst_n) begin
      chk(frm_valid == c, "R13 frm_valid", frm_valid, c);
      chk(rsp_valid == d, "R13 rsp_valid", rsp_valid, d);
    end
  endtask

  task automatic frame(input int req, input int addr, input int len, input string tag);
    int base; bit wr, rd;
    for (int i = 0; i < 16; i++) begin
      pl_we = 1; pl_idx = 4'(i); pl_byte = 8'(pl[i]); tick();
    end
    pl_we = 0;
    cmd_valid = 1; cmd_req = 4'(req); cmd_addr = 20'(addr); cmd_len = 5'(len);
    tick();
    cmd_valid = 0;
    base = req & 'hB;
    wr = (base == 0) || (base == 2) || (base == 8);
    rd = (base == 1) || (base == 9);
    e_err = !(wr || rd) ? 1 : ((wr && len > 16) || (rd && len > 19)) ? 2 : 0;
    for (int i = 0; i < 20; i++) eb[i] = 0;
    if (e_err == 0) begin
      eb[0] = (req << 4) | ((addr >> 16) & 15);
      eb[1] = (addr >> 8) & 255;
      eb[2] = addr & 255;
      if (len > 0) eb[3] = len - 1;
      if (wr) for (int i = 0; i < len; i++) eb[4 + i] = pl[i];
    end
    e_txl = (e_err != 0) ? 0 : (len == 0) ? 3 : wr ? 4 + len : 4;
    e_rxe = (e_err != 0) ? 0 : wr ? 2 : len + 1;
    e_key = (e_err == 0 && base == 8 && addr == int'(KEY)) ? 1 : 0;
    e_rd = rd; e_len = len;
    chk(frm_err == 2'(e_err), {tag, " err"}, frm_err, e_err);
    chk(frm_tx_len == 5'(e_txl), {tag, " tx_len"}, frm_tx_len, e_txl);
    chk(frm_rx_expect == 5'(e_rxe), {tag, " rx_expect"}, frm_rx_expect, e_rxe);
    chk(frm_key == e_key[0], {tag, " R9 key"}, frm_key, e_key);
    for (int k = 0; k < 5; k++) begin
      logic [31:0] w;
      w = {8'(eb[4*k]), 8'(eb[4*k+1]), 8'(eb[4*k+2]), 8'(eb[4*k+3])};
      tx_widx = 3'(k); #1;
      chk(tx_word == w, (k == 0) ? {tag, " R1 word0"} : {tag, " R2 word"}, tx_word, w);
    end
  endtask

  task automatic reply(input int rlen, input string tag);
    int ecnt, m; bit bad;
    for (int k = 0; k < 5; k++) begin
      rx_we = 1; rx_widx = 3'(k);
      rx_wdata = {8'(rb[4*k]), 8'(rb[4*k+1]), 8'(rb[4*k+2]), 8'(rb[4*k+3])};
      tick();
    end
    rx_we = 0;
    rx_done = 1; rx_len = 5'(rlen);
    tick();
    rx_done = 0;
    bad = (rlen == 0) || (rlen > 20) || (e_rxe == 0);
    m = (rlen < e_rxe) ? rlen : e_rxe;
    if (bad) ecnt = 0;
    else if (e_rd) ecnt = m - 1;
    else if (m > 1) ecnt = (rb[1] < e_len) ? rb[1] : e_len;
    else ecnt = e_len;
    chk(rsp_err == bad, {tag, " R12 err"}, rsp_err, bad);
    chk(rsp_code == 4'(rb[0] >> 4), {tag, " R10 code"}, rsp_code, rb[0] >> 4);
    chk(rsp_count == 5'(ecnt), {tag, " count"}, rsp_count, ecnt);
    if (e_rd)
      for (int i = 0; i < 20; i++) begin
        int eb8;
        eb8 = (i < ecnt) ? rb[i + 1] : 0;
        rd_idx = 5'(i); #1;
        chk(rd_byte == 8'(eb8), {tag, " R10 rd_byte"}, rd_byte, eb8);
      end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 16; i++) pl[i] = (seed + i * 17) & 255;
    for (int i = 0; i < 20; i++) rb[i] = (seed * 3 + i * 29 + 7) & 255;
  endtask

  initial begin
    repeat (3) tick();
    #1;
    chk(frm_valid == 0 && rsp_valid == 0, "R13 reset valid", {frm_valid, rsp_valid}, 0);
    chk(cmd_ready == 1, "R13 ready", cmd_ready, 1);
    chk(tx_word == 0, "R2 reset word", tx_word, 0);
    rst_n = 1;
    tick();

    fill(1); frame('h8, 'h12345, 5, "R4 native write");
    rb[0] = 'h20; reply(1, "R11 full length");
    rb[1] = 3;    reply(2, "R11 short write");
    rb[1] = 9;    reply(2, "R11 clamp");
    fill(2); frame('h2, 'h00ABC, 16, "R4 max write");
    fill(3); frame('h0, 'h00ABC, 17, "R5 write too long");
    reply(2, "R12 rejected frame");

    fill(4); frame('h9, 'hF0001, 6, "R6 native read");
    reply(7, "R10 exact");
    reply(10, "R10 extra discarded");
    reply(3, "R10 short");
    reply(0, "R12 zero length");
    reply(21, "R12 over length");
    fill(5); frame('h1, 'h00050, 19, "R6 max read");
    reply(20, "R10 full");
    fill(6); frame('h9, 'h00050, 20, "R5 read too long");

    fill(7); frame('h5, 'h00050, 0, "R3 R8 bare read");
    reply(1, "R10 bare reply");
    fill(8); frame('h4, 'h00051, 0, "R3 R8 bare write");
    fill(9); frame('hD, 'h1FFFF, 2, "R8 read bit2");
    fill(10); frame('hA, 'h00010, 3, "R7 invalid A");
    fill(11); frame('h3, 'h00010, 3, "R7 invalid 3");
    fill(12); frame('h8, KEY, 5, "R9 key write");
    fill(13); frame('hC, KEY, 5, "R9 R8 key write bit2");
    fill(14); frame('h9, KEY, 5, "R9 key read");
    fill(15); frame('h8, 'h68008, 5, "R9 other addr");

    tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule